// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block receives inbound message-signalled interrupt writes and turns them into level interrupt lines for a host processor. Software programs one 64-bit doorbell address. Every inbound write whose full address equals that doorbell carries a vector number in its data word. The block splits that number into a group (data / 32) and a bit (data % 32), and latches the event in the group's status register if the matching enable bit is set.

Vectors are arranged in groups of 32. Each group has its own enable, mask and status registers and drives its own interrupt line. A set mask bit hides a pending vector from the line but leaves it pending, so unmasking later raises the line again. Software clears serviced vectors by writing ones to the status register. A simple register bus with separate read and write strobes reaches all registers, and read data returns one cycle after the read strobe.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After reset every register reads as zero and every interrupt line is low.
- R2: The doorbell address low word is read/write at byte offset 0x00 and the high word at 0x04. Read data appears on regRdata at the clock edge that samples regRdEn.
- R3: For group n, enable is at 0x08 + 12n, mask at 0x0C + 12n and status at 0x10 + 12n. Offsets that are unaligned (low two bits not zero) or that map to no register read as zero, and writes to them change nothing.
- R4: An inbound write with msiValid high, msiAddr equal to {high word, low word} and msiData below 32 times the group count sets status bit msiData % 32 of group msiData / 32 at the next edge, when that enable bit is 1.
- R5: An inbound write sets no status bit when either address half differs, when msiData is 32 times the group count or more (no wrap-around), or when the target enable bit is 0.
- R6: irq[n] is high exactly while group n has a status bit whose mask bit is 0. It stays high across idle cycles until such bits are cleared or masked.
- R7: Masking a pending bit drops its effect on irq but keeps the status bit. A vector that arrives while masked is still latched, and unmasking raises irq again.
- R8: Writing the status register clears the bits written as 1. Bits written as 0 stay pending.
- R9: When an inbound write sets a status bit in the same cycle that software clears it, the bit stays set.
- R10: An event in group n raises only irq[n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | REG_AW | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, valid the cycle after regRdEn |
| msiValid | input | 1 | Inbound write valid |
| msiAddr | input | 64 | Inbound write address |
| msiData | input | 32 | Inbound write data (vector number) |
| irq | output | NUM_GRP | One level interrupt per group |

## Verification
Two functions can fall in the same cycle: an inbound doorbell hit that sets a status bit, and a software write-one-to-clear on the same status register. The bench drives both on the same falling edge, aimed at the same bit. It then reads the status back and checks the interrupt line, expecting the bit to be still pending. A following clear without a doorbell hit must then drop the bit and its line.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;

  localparam int GRP_IDX_W   = 8;
  localparam int VEC_PER_GRP = 32;
  localparam int DB_LO_OFS   = 0;
  localparam int DB_HI_OFS   = 4;
  localparam int GRP_BASE    = 8;
  localparam int GRP_STRIDE  = 12;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_DB_LO,
    FLD_DB_HI,
    FLD_ENABLE,
    FLD_MASK,
    FLD_STATUS
  } regField_e;

  typedef struct packed {
    logic                   wr;
    logic                   rd;
    regField_e              fld;
    logic [GRP_IDX_W-1:0]   grp;
    logic [VEC_PER_GRP-1:0] wdata;
  } regStrobe_t;

endpackage

// File: rtl/msi_db_regctl.sv
module msi_db_regctl
  import msi_db_pkg::*;
#(
  parameter int NUM_GRP = 8,
  parameter int REG_AW  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output regStrobe_t        stb
);

  always_comb begin
    stb       = '0;
    stb.wr    = regWrEn;
    stb.rd    = regRdEn;
    stb.wdata = regWdata;
    stb.fld   = FLD_NONE;
    if (regAddr[1:0] == 2'b00) begin
      if (int'(regAddr) == DB_LO_OFS) stb.fld = FLD_DB_LO;
      if (int'(regAddr) == DB_HI_OFS) stb.fld = FLD_DB_HI;
      for (int g = 0; g < NUM_GRP; g++) begin
        if (int'(regAddr) == GRP_BASE + GRP_STRIDE * g) begin
          stb.fld = FLD_ENABLE;
          stb.grp = GRP_IDX_W'(g);
        end
        if (int'(regAddr) == GRP_BASE + GRP_STRIDE * g + 4) begin
          stb.fld = FLD_MASK;
          stb.grp = GRP_IDX_W'(g);
        end
        if (int'(regAddr) == GRP_BASE + GRP_STRIDE * g + 8) begin
          stb.fld = FLD_STATUS;
          stb.grp = GRP_IDX_W'(g);
        end
      end
    end
  end

  AST_GRP_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fld == FLD_ENABLE || stb.fld == FLD_MASK || stb.fld == FLD_STATUS)
      |-> (int'(stb.grp) < NUM_GRP)); // R3

  AST_UNALIGNED_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr[1:0] != 2'b00) |-> (stb.fld == FLD_NONE)); // R3

endmodule

// File: rtl/msi_db_datapath.sv
module msi_db_datapath
  import msi_db_pkg::*;
#(
  parameter int NUM_GRP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  logic               msiValid,
  input  logic [63:0]        msiAddr,
  input  logic [31:0]        msiData,
  output logic [31:0]        regRdata,
  output logic [NUM_GRP-1:0] irq
);

  localparam int NUM_VEC = NUM_GRP * VEC_PER_GRP;
  localparam int VEC_W   = $clog2(NUM_VEC);
  localparam int GSEL_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  logic [31:0] dbLo, dbHi;
  logic [VEC_PER_GRP-1:0] enReg  [NUM_GRP];
  logic [VEC_PER_GRP-1:0] mskReg [NUM_GRP];
  logic [VEC_PER_GRP-1:0] staReg [NUM_GRP];
  logic [NUM_VEC-1:0] staFlat, enFlat;

  logic hit, hitEnabled;
  logic [GSEL_W-1:0] vecGrp;
  logic [4:0] vecBit;
  logic [VEC_W-1:0] vecIdx;
  logic clrAny;

  assign hit    = msiValid && (msiAddr == {dbHi, dbLo}) && (msiData < 32'(NUM_VEC));
  assign vecGrp = GSEL_W'(msiData >> 5);
  assign vecBit = msiData[4:0];
  assign vecIdx = msiData[VEC_W-1:0];
  assign hitEnabled = hit && enFlat[vecIdx];
  assign clrAny = stb.wr && (stb.fld == FLD_STATUS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dbLo <= '0;
      dbHi <= '0;
    end else if (stb.wr) begin
      if (stb.fld == FLD_DB_LO) dbLo <= stb.wdata;
      if (stb.fld == FLD_DB_HI) dbHi <= stb.wdata;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrp
    logic selG;
    logic [VEC_PER_GRP-1:0] setMask, clrMask;

    assign selG    = (stb.grp == GRP_IDX_W'(g));
    assign setMask = (hit && int'(vecGrp) == g)
                     ? ((VEC_PER_GRP'(1) << vecBit) & enReg[g]) : '0;
    assign clrMask = (clrAny && selG) ? stb.wdata : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enReg[g]  <= '0;
        mskReg[g] <= '0;
        staReg[g] <= '0;
      end else begin
        if (stb.wr && selG && stb.fld == FLD_ENABLE) enReg[g]  <= stb.wdata;
        if (stb.wr && selG && stb.fld == FLD_MASK)   mskReg[g] <= stb.wdata;
        staReg[g] <= (staReg[g] & ~clrMask) | setMask;
      end
    end

    assign irq[g] = |(staReg[g] & ~mskReg[g]);
    assign staFlat[g*VEC_PER_GRP +: VEC_PER_GRP] = staReg[g];
    assign enFlat[g*VEC_PER_GRP +: VEC_PER_GRP]  = enReg[g];

    AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (&mskReg[g]) |-> !irq[g]); // R6
  end

  logic [31:0] rdNext;
  always_comb begin
    rdNext = '0;
    case (stb.fld)
      FLD_DB_LO: rdNext = dbLo;
      FLD_DB_HI: rdNext = dbHi;
      default: begin
        for (int g = 0; g < NUM_GRP; g++) begin
          if (stb.grp == GRP_IDX_W'(g)) begin
            if (stb.fld == FLD_ENABLE) rdNext = enReg[g];
            if (stb.fld == FLD_MASK)   rdNext = mskReg[g];
            if (stb.fld == FLD_STATUS) rdNext = staReg[g];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)       regRdata <= '0;
    else if (stb.rd) regRdata <= rdNext;
  end

  AST_DOORBELL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    hitEnabled |=> staFlat[$past(vecIdx)]); // R4 R9

  AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rstN)
    !hitEnabled |=> ((staFlat & ~$past(staFlat)) == '0)); // R5

  AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !clrAny |=> ((staFlat & $past(staFlat)) == $past(staFlat))); // R7

endmodule

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
  import msi_db_pkg::*;
#(
  parameter int NUM_GRP = 8,
  localparam int REG_AW = $clog2(GRP_BASE + GRP_STRIDE * NUM_GRP)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic               msiValid,
  input  logic [63:0]        msiAddr,
  input  logic [31:0]        msiData,
  output logic [NUM_GRP-1:0] irq
);

  regStrobe_t stb;

  msi_db_regctl #(.NUM_GRP(NUM_GRP), .REG_AW(REG_AW)) u_regctl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .stb      (stb)
  );

  msi_db_datapath #(.NUM_GRP(NUM_GRP)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .msiValid (msiValid),
    .msiAddr  (msiAddr),
    .msiData  (msiData),
    .regRdata (regRdata),
    .irq      (irq)
  );

endmodule

// File: tb/msi_doorbell_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_doorbell_ctrl_tb_top;

  localparam logic [31:0] DB_LO = 32'hA000_0000;
  localparam logic [31:0] DB_HI = 32'h0000_0001;

  // {mode, data, expected irq}; mode 0 = doorbell hit, 1 = low half wrong, 2 = high half wrong
  localparam logic [41:0] VEC_TBL [8] = '{
    {2'd0, 32'd5,   8'h01},
    {2'd1, 32'd40,  8'h01},
    {2'd2, 32'd40,  8'h01},
    {2'd0, 32'd40,  8'h03},
    {2'd0, 32'd116, 8'h03},
    {2'd0, 32'd98,  8'h0B},
    {2'd0, 32'd289, 8'h0B},
    {2'd0, 32'd255, 8'h8B}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [6:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic msiValid = 1'b0;
  logic [63:0] msiAddr = '0;
  logic [31:0] msiData = '0;
  logic [7:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  msi_doorbell_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .msiValid(msiValid), .msiAddr(msiAddr), .msiData(msiData), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic regWrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdata;
  endtask

  task automatic msiSend(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    msiValid = 1'b1; msiAddr = a; msiData = d;
    @(negedge clk);
    msiValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] a;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    regRead(7'h00, rd); chk("R1 dbLo", rd, 32'h0);
    regRead(7'h08, rd); chk("R1 enable0", rd, 32'h0);
    regRead(7'h64, rd); chk("R1 status7", rd, 32'h0);

    // R2 doorbell address
    regWrite(7'h00, DB_LO);
    regWrite(7'h04, DB_HI);
    regRead(7'h00, rd); chk("R2 dbLo", rd, DB_LO);
    regRead(7'h04, rd); chk("R2 dbHi", rd, DB_HI);

    for (int g = 0; g < 8; g++)
      regWrite(7'(8 + 12 * g), (g == 3) ? 32'h0000_FFFF : 32'hFFFF_FFFF);

    // R3 map, unaligned and unmapped offsets
    regRead(7'h2C, rd); chk("R3 enable3", rd, 32'h0000_FFFF);
    regWrite(7'h0A, 32'h0);
    regRead(7'h08, rd); chk("R3 unaligned write ignored", rd, 32'hFFFF_FFFF);
    regWrite(7'h68, 32'hFFFF_FFFF);
    regRead(7'h68, rd); chk("R3 unmapped read", rd, 32'h0);

    // R4 R5 R10 vector table
    for (int i = 0; i < 8; i++) begin
      case (VEC_TBL[i][41:40])
        2'd0:    a = {DB_HI, DB_LO};
        2'd1:    a = {DB_HI, DB_LO ^ 32'h1};
        default: a = {32'h0, DB_LO};
      endcase
      msiSend(a, VEC_TBL[i][39:8]);
      chk($sformatf("R4/R5/R10 vector row %0d", i), 32'(irq), 32'(VEC_TBL[i][7:0]));
    end
    regRead(7'h1C, rd); chk("R5 no wrap into group1", rd, 32'h0000_0100);
    regRead(7'h34, rd); chk("R5 disabled bit group3", rd, 32'h0000_0004);
    regRead(7'h64, rd); chk("R4 group7 bit31", rd, 32'h8000_0000);

    // R6 level held
    repeat (3) @(negedge clk);
    chk("R6 level held", 32'(irq), 32'h8B);

    // R7 masking keeps pending
    regWrite(7'h0C, 32'h20);
    chk("R7 masked irq0 low", 32'(irq), 32'h8A);
    regRead(7'h10, rd); chk("R7 status kept", rd, 32'h20);
    regWrite(7'h0C, 32'h0);
    chk("R7 unmask irq0", 32'(irq), 32'h8B);

    // R8 write-one-to-clear
    regWrite(7'h10, 32'h0);
    regRead(7'h10, rd); chk("R8 zero write keeps", rd, 32'h20);
    regWrite(7'h10, 32'h20);
    regRead(7'h10, rd); chk("R8 one clears", rd, 32'h0);
    chk("R8 irq0 low", 32'(irq), 32'h8A);
    regWrite(7'h1C, 32'h1);
    regRead(7'h1C, rd); chk("R8 other bits kept", rd, 32'h100);

    // R9 set wins over clear in the same cycle
    @(negedge clk);
    msiValid = 1'b1; msiAddr = {DB_HI, DB_LO}; msiData = 32'd40;
    regWrEn = 1'b1; regAddr = 7'h1C; regWdata = 32'h100;
    @(negedge clk);
    msiValid = 1'b0; regWrEn = 1'b0;
    regRead(7'h1C, rd); chk("R9 set wins", rd, 32'h100);
    chk("R9 irq1 high", 32'(irq), 32'h8A);
    regWrite(7'h1C, 32'h100);
    chk("R9 later clear", 32'(irq), 32'h88);

    // R7 vector arriving while masked
    regWrite(7'h24, 32'h1);
    msiSend({DB_HI, DB_LO}, 32'd64);
    chk("R7 masked arrival irq", 32'(irq), 32'h88);
    regRead(7'h28, rd); chk("R7 masked arrival latched", rd, 32'h1);
    regWrite(7'h24, 32'h0);
    chk("R7 unmask raises", 32'(irq), 32'h8C);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule